// File: doc/BRIEF.md
# Status-First I2C Command Slave

This block is the two-wire serial front end of a data-recovery peripheral. An external controller sends it short write commands and reads back recovered data. A write command is either a single command byte or a command byte followed by one argument byte. The command byte decides which form applies, so the slave acknowledges exactly the bytes it expects and lets the rest go unacknowledged. Each complete command reaches the core as a single-cycle strobe that carries the code, the argument and a flag that says whether an argument is present.

Every read transfer begins with a status byte. The status byte reports whether the core can take a command, whether data is staged, and whether one or two bytes are staged. The core stages data through a load port. The controller then reads the status byte and as many staged bytes as it wants. The availability flag clears only once the final staged byte has been shifted out completely. A read that ends early leaves the flag and the data in place.

The serial lines are synchronised and filtered in the system clock domain. The slave pulls SDA low through an open-drain enable. It never stretches the clock.

Top module: `i2c_status_slave`

## Requirements
- R1: The slave responds only to 7-bit address 0x14. The write form of the address byte is 0x28 and the read form is 0x29. Any other address byte gets no acknowledge, and every later byte up to the next START is ignored without an acknowledge.
- R2: In a write, the slave always acknowledges the command byte. If bit 7 of the command byte is 1, the slave also acknowledges one argument byte and then pulses `cmd_valid` for one cycle with `cmd_has_arg`=1. If bit 7 is 0, the slave pulses `cmd_valid` right after the command byte with `cmd_has_arg`=0.
- R3: Once a command is complete, every further written byte is left unacknowledged (SDA released on the ACK slot) and produces no strobe.
- R4: The first byte of every read is the status byte: bit 7 is `core_ready`, bit 6 is DAV (data staged), bit 5 is RD2 (two bytes staged), and bits 4..0 are 0. All bytes are sent MSB first.
- R5: A one-cycle `load_valid` stages `load_data0`, and also `load_data1` when `load_two`=1. It sets DAV=1 and sets RD2 equal to `load_two`. A load wins over a clear in the same cycle. Staged bytes are read out in the order data0, data1.
- R6: DAV and RD2 clear when the eighth bit of the last staged byte is clocked out. A read of status only, or a read that stops before the last staged byte, leaves DAV, RD2 and the data unchanged, and the next read starts again at data0.
- R7: A read byte requested beyond the staged count reads as 0xFF, because SDA stays released.
- R8: A repeated START begins a fresh address phase without a STOP in between. A STOP releases SDA and ends the transfer.
- R9: The SDA drive enable changes only while SCL is low.
- R10: A pulse on SCL or SDA that lasts fewer than three synchronised samples has no effect on the transfer.
- R11: After reset, SDA is released, no strobe is issued, and DAV and RD2 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| core_ready | input | 1 | Core can accept a command; reported in status bit 7 |
| cmd_valid | output | 1 | One-cycle strobe for a completed command |
| cmd_code | output | 8 | Command byte of the completed command |
| cmd_arg | output | 8 | Argument byte, meaningful when cmd_has_arg is 1 |
| cmd_has_arg | output | 1 | Command carried an argument byte |
| load_valid | input | 1 | Stage read data this cycle |
| load_two | input | 1 | 1: stage two bytes, 0: stage one byte |
| load_data0 | input | 8 | First staged byte |
| load_data1 | input | 8 | Second staged byte |

## Verification
The hardest state to reach is a read that stops part-way through the staged data. The controller must ACK the status byte and then NACK data0 while two bytes are staged. The bench drives that exact pattern and then confirms through a fresh read that the status byte still shows 0xE0 and that data0 comes out again. Two other cases only appear when the controller breaks the normal pattern, so the bench scripts them directly: a repeated START that turns a write into a read with no STOP, and one-clock glitches injected on SCL during the low phase and on SDA while SCL is high. Throughout the run, a per-clock monitor compares every edge of the SDA drive enable against the driven SCL level.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_IGNORE
    } slv_state_e;

    typedef enum logic [1:0] {
        WP_CMD,
        WP_ARG,
        WP_DONE
    } wr_phase_e;

    typedef struct packed {
        logic rdy;
        logic dav;
        logic rd2;
    } status_t;

    localparam logic [7:0] RELEASED_BYTE = 8'hFF;

    // Status layout: ready in bit 7, data-available in bit 6, two-bytes in bit 5.
    function automatic logic [7:0] status_byte(status_t s);
        return {s.rdy, s.dav, s.rd2, 5'b00000};
    endfunction

    // Command-length rule: a set top bit means one argument byte follows.
    function automatic logic cmd_takes_arg(logic [7:0] code);
        return code[7];
    endfunction

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&win_q)
                filt_o <= 1'b1;
            else if (~|win_q)
                filt_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign ev_start = scl_f & scl_p & sda_p & ~sda_f;
    assign ev_stop  = scl_f & scl_p & ~sda_p & sda_f;
    assign ev_rise  = scl_f & ~scl_p;
    assign ev_fall  = ~scl_f & scl_p;
endmodule

// File: rtl/i2cs_stage.sv
module i2cs_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_valid,
    input  logic          load_two,
    input  logic [DW-1:0] load_data0,
    input  logic [DW-1:0] load_data1,
    input  logic          clear,
    output logic          dav,
    output logic          rd2,
    output logic [DW-1:0] data0,
    output logic [DW-1:0] data1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dav   <= 1'b0;
            rd2   <= 1'b0;
            data0 <= '0;
            data1 <= '0;
        end else if (load_valid) begin
            dav   <= 1'b1;
            rd2   <= load_two;
            data0 <= load_data0;
            data1 <= load_two ? load_data1 : data1;
        end else if (clear) begin
            dav <= 1'b0;
            rd2 <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h14,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       core_ready,
    output logic       cmd_valid,
    output logic [7:0] cmd_code,
    output logic [7:0] cmd_arg,
    output logic       cmd_has_arg,
    input  logic       load_valid,
    input  logic       load_two,
    input  logic [7:0] load_data0,
    input  logic [7:0] load_data1
);
    localparam int LINES = 2;
    localparam int BITS  = 8;

    logic [LINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2cs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_lines[g]),
            .filt_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2cs_bus_events u_ev (
        .clk     (clk),
        .rst     (rst),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    logic       dav, rd2, dav_clr;
    logic [7:0] data0, data1;

    i2cs_stage #(.DW(8)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .load_valid(load_valid),
        .load_two  (load_two),
        .load_data0(load_data0),
        .load_data1(load_data1),
        .clear     (dav_clr),
        .dav       (dav),
        .rd2       (rd2),
        .data0     (data0),
        .data1     (data1)
    );

    status_t    stat;
    slv_state_e state;
    wr_phase_e  phase;
    logic [3:0] cnt;
    logic [7:0] sh, tx;
    logic       rw;
    logic [1:0] rd_idx, rd_avail, nxt_idx;
    logic [7:0] nxt_byte;

    assign stat = '{rdy: core_ready, dav: dav, rd2: rd2};
    assign nxt_idx = (rd_idx == 2'd3) ? 2'd3 : rd_idx + 2'd1;

    always_comb begin
        nxt_byte = RELEASED_BYTE;
        if (nxt_idx <= rd_avail)
            nxt_byte = (nxt_idx == 2'd1) ? data0 : data1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            phase       <= WP_CMD;
            cnt         <= '0;
            sh          <= '0;
            tx          <= '0;
            rw          <= 1'b0;
            rd_idx      <= '0;
            rd_avail    <= '0;
            sda_oe      <= 1'b0;
            cmd_valid   <= 1'b0;
            cmd_code    <= '0;
            cmd_arg     <= '0;
            cmd_has_arg <= 1'b0;
            dav_clr     <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            dav_clr   <= 1'b0;
            if (ev_start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev_stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev_rise && cnt < BITS) begin
                            sh  <= {sh[6:0], sda_f};
                            cnt <= cnt + 4'd1;
                        end
                        if (ev_fall && cnt == BITS) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                rd_idx   <= 2'd0;
                                rd_avail <= dav ? (rd2 ? 2'd2 : 2'd1) : 2'd0;
                                tx       <= status_byte(stat);
                                sda_oe   <= ~stat.rdy;
                                state    <= ST_RD_BYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= WP_CMD;
                                state  <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (ev_rise && cnt < BITS) begin
                            sh  <= {sh[6:0], sda_f};
                            cnt <= cnt + 4'd1;
                        end
                        if (ev_fall && cnt == BITS) begin
                            state <= ST_WR_ACK;
                            case (phase)
                                WP_CMD: begin
                                    sda_oe   <= 1'b1;
                                    cmd_code <= sh;
                                    if (cmd_takes_arg(sh)) begin
                                        phase <= WP_ARG;
                                    end else begin
                                        cmd_valid   <= 1'b1;
                                        cmd_has_arg <= 1'b0;
                                        phase       <= WP_DONE;
                                    end
                                end
                                WP_ARG: begin
                                    sda_oe      <= 1'b1;
                                    cmd_arg     <= sh;
                                    cmd_valid   <= 1'b1;
                                    cmd_has_arg <= 1'b1;
                                    phase       <= WP_DONE;
                                end
                                default: sda_oe <= 1'b0;
                            endcase
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev_rise && cnt < BITS) begin
                            cnt <= cnt + 4'd1;
                            if (cnt == 4'd7 && rd_idx != 2'd0 && rd_idx == rd_avail)
                                dav_clr <= 1'b1;
                        end
                        if (ev_fall) begin
                            if (cnt == BITS) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                sda_oe <= ~tx[3'd7 - cnt[2:0]];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev_rise)
                            state <= sda_f ? ST_IGNORE : ST_RD_NEXT;
                    end
                    ST_RD_NEXT: begin
                        if (ev_fall) begin
                            rd_idx <= nxt_idx;
                            tx     <= nxt_byte;
                            sda_oe <= ~nxt_byte[7];
                            cnt    <= '0;
                            state  <= ST_RD_BYTE;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_checks.sv
module i2cs_checks (
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input logic       scl_f,
    input logic       ev_stop,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic       cmd_has_arg,
    input logic       load_valid,
    input logic       load_two,
    input logic       dav,
    input logic       rd2
);
    // R9: drive enable only moves while filtered SCL is low
    a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f);

    // R8: a STOP always leaves SDA released
    a_r8_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !sda_oe);

    // R2: the command strobe lasts one cycle
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R2: argument flag follows the command-length rule
    a_r2_arg_matches_code: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_has_arg == cmd_code[7]));

    // R5: a load sets DAV and RD2 from the byte count
    a_r5_load_sets_dav: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> (dav && (rd2 == $past(load_two))));

    // R5: RD2 never stands without DAV
    a_r5_rd2_needs_dav: assert property (@(posedge clk) disable iff (rst)
        rd2 |-> dav);
endmodule

bind i2c_status_slave i2cs_checks i_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_oe     (sda_oe),
    .scl_f      (scl_f),
    .ev_stop    (ev_stop),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_has_arg(cmd_has_arg),
    .load_valid (load_valid),
    .load_two   (load_two),
    .dav        (dav),
    .rd2        (rd2)
);

// File: tb/test_i2c_status_slave.sv
module test_i2c_status_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic core_ready = 1'b1;
    logic load_valid = 1'b0, load_two = 1'b0;
    logic [7:0] load_data0 = '0, load_data1 = '0;
    logic sda_oe, cmd_valid, cmd_has_arg;
    logic [7:0] cmd_code, cmd_arg;
    wire  sda_line = sda_m & ~sda_oe;

    int tests = 0, fails = 0, cyc = 0;
    int got_n = 0;
    logic [7:0] got_code, got_arg;
    logic got_has;
    logic prev_oe = 1'b0;
    int   oe_bad = 0;
    bit   done = 0;
    byte unsigned stage_q[$];

    always #2.5 clk = ~clk;

    i2c_status_slave i_i2c_status_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .core_ready(core_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .cmd_has_arg(cmd_has_arg), .load_valid(load_valid),
        .load_two(load_two), .load_data0(load_data0), .load_data1(load_data1)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock monitor: strobe capture and drive-enable timing (R9)
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (cmd_valid) begin
                got_n++;
                got_code = cmd_code;
                got_arg  = cmd_arg;
                got_has  = cmd_has_arg;
            end
            if (sda_oe !== prev_oe && scl_m !== 1'b0) begin
                oe_bad++;
                $display("FAIL R9 oe changed with SCL high actual %0h expected 0", scl_m);
            end
            prev_oe = sda_oe;
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual %0d expected <150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic wbit(bit b, bit glitch);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        if (glitch) begin
            sda_m = ~b; wq(1); sda_m = b;
        end
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbit(output bit b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic wbyte(logic [7:0] v, int glitch_bit, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) wbit(v[i], i == glitch_bit);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~ack, 1'b0);
    endtask

    function automatic logic [7:0] exp_status();
        return {core_ready, stage_q.size() > 0, stage_q.size() == 2, 5'b0};
    endfunction

    task automatic do_load(bit two, logic [7:0] d0, logic [7:0] d1);
        @(negedge clk);
        load_valid = 1'b1; load_two = two; load_data0 = d0; load_data1 = d1;
        @(negedge clk);
        load_valid = 1'b0;
        stage_q = {};
        stage_q.push_back(d0);
        if (two) stage_q.push_back(d1);
    endtask

    // read n bytes (status first); compare against the model
    task automatic rd_seq(string tag, int n);
        bit ack;
        logic [7:0] v, e;
        int avail = stage_q.size();
        bus_start();
        wbyte(8'h29, -1, ack);
        chk({tag, " R1 read address ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            if (i == 0) e = exp_status();
            else if (i <= avail) e = stage_q[i-1];
            else e = 8'hFF;
            rbyte(i < n - 1, v);
            chk($sformatf("%s byte%0d", tag, i), v, e);
        end
        bus_stop();
        if (avail > 0 && n - 1 >= avail) stage_q = {};
    endtask

    // write command (and optional argument / extra byte)
    task automatic wr_seq(string tag, logic [7:0] c, logic [7:0] a, int nbytes);
        bit ack;
        int n0 = got_n;
        bit has = c[7];
        bus_start();
        wbyte(8'h28, -1, ack);
        chk({tag, " R1 write address ack"}, ack, 1);
        wbyte(c, -1, ack);
        chk({tag, " R2 command ack"}, ack, 1);
        if (nbytes > 1) begin
            wbyte(a, -1, ack);
            chk({tag, has ? " R2 argument ack" : " R3 extra byte nack"}, ack, has);
        end
        if (nbytes > 2) begin
            wbyte(8'h55, -1, ack);
            chk({tag, " R3 byte beyond command nack"}, ack, 0);
        end
        bus_stop();
        chk({tag, " R2 strobe count"}, got_n - n0, (has && nbytes < 2) ? 0 : 1);
        if (got_n - n0 == 1) begin
            chk({tag, " R2 code"}, got_code, c);
            chk({tag, " R2 has_arg"}, got_has, has);
            if (has) chk({tag, " R2 argument"}, got_arg, a);
        end
    endtask

    initial begin
        bit ack;
        logic [7:0] v;
        int n0;
        wq(5);
        rst = 1'b0;
        wq(2);
        // R11: reset state
        chk("R11 sda released", sda_oe, 0);
        chk("R11 no strobe", cmd_valid, 0);
        rd_seq("R11 R4 idle status", 1);

        core_ready = 1'b0;
        rd_seq("R4 not ready status", 1);
        core_ready = 1'b1;

        // R1: foreign address ignored
        n0 = got_n;
        bus_start();
        wbyte(8'h2A, -1, ack);
        chk("R1 foreign address nack", ack, 0);
        wbyte(8'h85, -1, ack);
        chk("R1 later byte ignored", ack, 0);
        bus_stop();
        chk("R1 no strobe", got_n - n0, 0);

        wr_seq("R2 short cmd", 8'h05, 8'h00, 1);
        wr_seq("R3 short cmd extra", 8'h05, 8'h77, 2);
        wr_seq("R2 long cmd", 8'h9A, 8'h3C, 2);
        wr_seq("R3 long cmd extra", 8'hC1, 8'hA5, 3);

        // R5/R6: two bytes staged, status-only read keeps them
        do_load(1'b1, 8'h5A, 8'hC3);
        rd_seq("R5 status after load2", 1);
        rd_seq("R6 status kept", 1);
        // R6: partial read keeps data, restart at data0
        rd_seq("R6 partial read", 2);
        rd_seq("R6 full read", 3);
        rd_seq("R6 status after drain", 1);

        // R5/R7: one byte staged, asking for two
        do_load(1'b0, 8'h81, 8'h00);
        rd_seq("R7 one staged over-read", 3);
        rd_seq("R6 cleared after one", 1);
        rd_seq("R7 no data read", 2);

        // R8: repeated START from write into read
        n0 = got_n;
        do_load(1'b0, 8'h3E, 8'h00);
        bus_start();
        wbyte(8'h28, -1, ack);
        wbyte(8'h11, -1, ack);
        chk("R8 command ack", ack, 1);
        bus_start();
        wbyte(8'h29, -1, ack);
        chk("R8 read address after repeated start", ack, 1);
        rbyte(1'b1, v);
        chk("R8 status after repeated start", v, 8'hC0);
        rbyte(1'b0, v);
        chk("R8 data after repeated start", v, 8'h3E);
        bus_stop();
        stage_q = {};
        chk("R8 strobe", got_n - n0, 1);
        chk("R8 code", got_code, 8'h11);
        chk("R8 sda released after stop", sda_oe, 0);

        // R10: SCL glitch in low phase, SDA glitch on a high bit
        n0 = got_n;
        bus_start();
        wbyte(8'h28, -1, ack);
        scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q);
        wbyte(8'h07, 2, ack);
        chk("R10 command ack through glitches", ack, 1);
        bus_stop();
        chk("R10 strobe count", got_n - n0, 1);
        chk("R10 code intact", got_code, 8'h07);

        wq(10);
        chk("R9 drive enable edges", oe_bad, 0);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule